// File: doc/BRIEF.md
# Vector Command Queue Dispatcher

This block sits between a scalar issue pipe and the vector execution side. Commands arrive one per cycle through a valid/ready enqueue port. Each command carries a two-bit kind tag, an occupancy count and an opaque payload. The commands wait in a small circular queue. The head of the queue is handed to the sequencer that matches its kind: arithmetic, load or store. This happens in the first cycle in which that sequencer can take work.

Each of the three sequencers holds one command at a time. It stays busy for the occupancy count of that command. The sequencers are tracked independently, so several of them can be busy together with commands that left the queue on different cycles. Ordering is strict. At most one command leaves per cycle, always the head, and a waiting command never overtakes the head even when its own sequencer is free. A head carrying the reserved kind code raises an error flag and stays where it is until reset.

Top module: `vcq_dispatcher`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the queue empties and all sequencers clear. After reset `q_level` is 0, `in_ready` is 1, and `seq_busy`, `iss_valid` and `err_illegal` are all 0.
- R2: A command is accepted in a cycle where `in_valid` and `in_ready` are both high, and `q_level` rises by one for each accepted command not matched by a dispatch. `in_ready` is low only when `q_level` equals DEPTH and no dispatch happens in that cycle.
- R3: When the queue is full and the head is dispatched in a cycle, `in_ready` is high in that cycle, and an enqueue and a dispatch take effect together.
- R4: At most one bit of `iss_valid` is high in any cycle.
- R5: Commands are dispatched in arrival order. A command accepted in cycle c can be dispatched at the earliest in cycle c+1. A command behind a stalled head waits even if its own sequencer is idle.
- R6: The kind tag selects the port: 2'b00 arithmetic (`iss_valid[0]`), 2'b01 load (`iss_valid[1]`), 2'b10 store (`iss_valid[2]`). Port k carries the payload on `iss_data[k*DATA_W +: DATA_W]` in its dispatch cycle. The head is dispatched in the first cycle its sequencer can take it.
- R7: A command with occupancy N≥1 dispatched in cycle c holds `seq_busy[k]` high in cycles c+1 through c+N.
- R8: The sequencer can take a new command in the last cycle of its busy period. A same-kind follower that is already at the head is dispatched exactly N cycles after its predecessor, so there is no idle gap.
- R9: The three sequencers run independently. One busy sequencer does not delay dispatch to another, and two or three `seq_busy` bits can be high at once.
- R10: An occupancy of 0 behaves exactly like an occupancy of 1.
- R11: A head with kind 2'b11 drives `err_illegal` high, is never dispatched, and stays queued, which keeps `q_level` unchanged and blocks everything behind it until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Enqueue request |
| in_ready | output | 1 | Queue can accept this cycle |
| in_kind | input | 2 | Command kind tag |
| in_occ | input | OCC_W | Occupancy cycle count (0 means 1) |
| in_data | input | DATA_W | Command payload |
| iss_valid | output | 3 | Per-sequencer dispatch strobe (0 arith, 1 load, 2 store) |
| iss_data | output | 3*DATA_W | Per-sequencer payload, slice k for sequencer k |
| seq_busy | output | 3 | Per-sequencer busy status |
| q_level | output | $clog2(DEPTH+1) | Number of queued commands |
| err_illegal | output | 1 | Head holds the reserved kind code |

## Verification
The bench builds the block with DEPTH=3, OCC_W=4 and DATA_W=8. The shallow queue fills within a few commands, so the full-queue enqueue-with-dispatch case is reached in most sequences. The 4-bit occupancy lets every count from 0 up to the maximum of 15 be swept for every kind. The bench works out each command's acceptance and dispatch cycles from the requirement rules. It then compares every output in every cycle, both for sweeps of same-kind trains and for pseudo-random mixed sequences.

// File: rtl/vcq_pkg.sv
// Package vcq_pkg
// Shared kind encoding and sequencer count for the vector command dispatcher.
// Assumes the kind code equals the index of the sequencer it targets.
package vcq_pkg;
    localparam int VCQ_NSEQ   = 3;
    localparam int VCQ_KIND_W = 2;

    typedef enum logic [VCQ_KIND_W-1:0] {
        VCQ_ARITH = 2'b00,
        VCQ_LOAD  = 2'b01,
        VCQ_STORE = 2'b10,
        VCQ_BAD   = 2'b11
    } vcq_kind_e;
endpackage

// File: rtl/vcq_fifo.sv
// Module vcq_fifo
// Circular command queue with a combinational head view and an occupancy level.
// Assumes the caller never pushes when full unless it pops in the same cycle,
// and never pops when empty. Synchronous active-low reset empties it.
module vcq_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 26,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic             empty,
    output logic             full,
    output logic [LVL_W-1:0] level
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;
    logic [LVL_W-1:0] cnt;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= ptr_inc(wr_ptr);
            if (pop)  rd_ptr <= ptr_inc(rd_ptr);
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Entry storage write.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    assign rdata = mem[rd_ptr];
    assign empty = (cnt == '0);
    assign full  = (cnt == LVL_W'(DEPTH));
    assign level = cnt;

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));
    a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/vcq_seq_timer.sv
// Module vcq_seq_timer
// Busy tracker for one execution sequencer: loads the occupancy at dispatch
// and counts down. It can take new work in its last busy cycle.
// Assumes start only arrives while can_take is high.
module vcq_seq_timer #(
    parameter int OCC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [OCC_W-1:0] occ,
    output logic             busy,
    output logic             can_take
);
    logic [OCC_W-1:0] cnt;
    logic [OCC_W-1:0] load_val;

    // A zero count is stretched to one cycle.
    always_comb begin
        load_val = (occ == '0) ? OCC_W'(1) : occ;
    end

    // Remaining busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy     = (cnt != '0);
    assign can_take = (cnt <= OCC_W'(1));

    a_r7_start_only_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> can_take);
    a_r7_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    a_r10_short_occ_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (start && occ <= OCC_W'(1)) |=> can_take);
endmodule

// File: rtl/vcq_head_route.sv
// Module vcq_head_route
// Decides whether the queue head goes out this cycle, and to which sequencer.
// Only the sequencer matching the head kind gates the pop; the reserved kind
// is flagged and never popped.
module vcq_head_route
    import vcq_pkg::*;
#(
    parameter int NSEQ = VCQ_NSEQ
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  head_valid,
    input  logic [VCQ_KIND_W-1:0] head_kind,
    input  logic [NSEQ-1:0]       seq_ready,
    output logic [NSEQ-1:0]       fire,
    output logic                  pop,
    output logic                  illegal
);
    genvar k;
    generate
        for (k = 0; k < NSEQ; k++) begin : g_fire
            // Dispatch strobe for sequencer k.
            always_comb begin
                fire[k] = head_valid && (head_kind == VCQ_KIND_W'(k)) && seq_ready[k];
            end
        end
    endgenerate

    // Pop and illegal-kind flag.
    always_comb begin
        pop     = |fire;
        illegal = head_valid && (head_kind == VCQ_BAD);
    end

    a_r4_single_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fire));
    a_r11_illegal_held: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !pop);
endmodule

// File: rtl/vcq_dispatcher.sv
// Module vcq_dispatcher (top)
// Queues vector commands from the scalar pipe and dispatches them in order,
// one per cycle, to arithmetic, load and store sequencers whose busy periods
// are tracked independently. Entry layout is {kind, occ, data}.
// Synchronous active-low reset.
module vcq_dispatcher
    import vcq_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int OCC_W  = 8,
    parameter int DATA_W = 16,
    localparam int LVL_W   = $clog2(DEPTH + 1),
    localparam int ENTRY_W = VCQ_KIND_W + OCC_W + DATA_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [VCQ_KIND_W-1:0]      in_kind,
    input  logic [OCC_W-1:0]           in_occ,
    input  logic [DATA_W-1:0]          in_data,
    output logic [VCQ_NSEQ-1:0]        iss_valid,
    output logic [VCQ_NSEQ*DATA_W-1:0] iss_data,
    output logic [VCQ_NSEQ-1:0]        seq_busy,
    output logic [LVL_W-1:0]           q_level,
    output logic                       err_illegal
);
    logic [ENTRY_W-1:0]    head;
    logic                  q_empty;
    logic                  q_full;
    logic                  push;
    logic                  pop;
    logic [VCQ_NSEQ-1:0]   seq_ready;
    logic [VCQ_NSEQ-1:0]   fire;
    logic [VCQ_KIND_W-1:0] head_kind;
    logic [OCC_W-1:0]      head_occ;
    logic [DATA_W-1:0]     head_data;

    // Enqueue handshake; a full queue still accepts when the head leaves.
    always_comb begin
        in_ready = !q_full || pop;
        push     = in_valid && in_ready;
    end

    // Field split of the head entry.
    always_comb begin
        {head_kind, head_occ, head_data} = head;
    end

    vcq_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata ({in_kind, in_occ, in_data}),
        .pop   (pop),
        .rdata (head),
        .empty (q_empty),
        .full  (q_full),
        .level (q_level)
    );

    vcq_head_route #(.NSEQ(VCQ_NSEQ)) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_valid (!q_empty),
        .head_kind  (head_kind),
        .seq_ready  (seq_ready),
        .fire       (fire),
        .pop        (pop),
        .illegal    (err_illegal)
    );

    genvar k;
    generate
        for (k = 0; k < VCQ_NSEQ; k++) begin : g_seq
            vcq_seq_timer #(.OCC_W(OCC_W)) u_timer (
                .clk      (clk),
                .rst_n    (rst_n),
                .start    (fire[k]),
                .occ      (head_occ),
                .busy     (seq_busy[k]),
                .can_take (seq_ready[k])
            );
            // Payload to sequencer k, zero when it is not being dispatched.
            always_comb begin
                iss_data[k*DATA_W +: DATA_W] = fire[k] ? head_data : '0;
            end
        end
    endgenerate

    assign iss_valid = fire;

    a_r5_head_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_empty && !pop) |=> $stable(head));
    a_r2_ready_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (q_level == LVL_W'(DEPTH) && iss_valid == '0) |-> !in_ready);
    a_r3_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && in_valid && pop) |=> (q_level == LVL_W'(DEPTH)));
endmodule

// File: tb/vcq_dispatcher_tb.sv
`timescale 1ns/1ps
module vcq_dispatcher_tb;
    localparam int DEPTH  = 3;
    localparam int OCC_W  = 4;
    localparam int DATA_W = 8;
    localparam int LVL_W  = $clog2(DEPTH + 1);
    localparam int MAXN   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [1:0] in_kind = '0;
    logic [OCC_W-1:0] in_occ = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic [2:0] iss_valid;
    logic [3*DATA_W-1:0] iss_data;
    logic [2:0] seq_busy;
    logic [LVL_W-1:0] q_level;
    logic err_illegal;

    int total = 0;
    int bad = 0;
    int wd = 0;
    int c_kind [MAXN];
    int c_occ  [MAXN];
    int c_data [MAXN];
    int e_exp  [MAXN];
    int i_exp  [MAXN];
    logic [31:0] rng = 32'h1234_5678;

    always #2.5 clk = ~clk;

    vcq_dispatcher #(.DEPTH(DEPTH), .OCC_W(OCC_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_kind(in_kind), .in_occ(in_occ), .in_data(in_data),
        .iss_valid(iss_valid), .iss_data(iss_data), .seq_busy(seq_busy),
        .q_level(q_level), .err_illegal(err_illegal)
    );

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog expired actual=%0d expected<=150000", wd);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int eff(input int o);
        return (o == 0) ? 1 : o;
    endfunction

    function automatic int rnd(input int m);
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return int'(rng % m);
    endfunction

    // Reset and check the cleared state (R1).
    task automatic reset_dut();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk(q_level == 0, "R1 level", int'(q_level), 0);
        chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
        chk(seq_busy == 3'b000, "R1 busy", int'(seq_busy), 0);
        chk(iss_valid == 3'b000, "R1 issue", int'(iss_valid), 0);
        chk(err_illegal == 1'b0, "R1 err", int'(err_illegal), 0);
    endtask

    // Expected accept and dispatch cycles from the ordering rules.
    task automatic plan(input int n);
        int fr [3];
        for (int k = 0; k < 3; k++) fr[k] = 0;
        for (int i = 0; i < n; i++) begin
            int e;
            int s;
            e = (i == 0) ? 0 : e_exp[i-1] + 1;
            if (i >= DEPTH && i_exp[i-DEPTH] > e) e = i_exp[i-DEPTH];
            s = e + 1;
            if (i > 0 && i_exp[i-1] + 1 > s) s = i_exp[i-1] + 1;
            if (fr[c_kind[i]] > s) s = fr[c_kind[i]];
            e_exp[i] = e;
            i_exp[i] = s;
            fr[c_kind[i]] = s + eff(c_occ[i]);
        end
    endtask

    // Drive a sequence and compare every output in every cycle.
    task automatic run(input int n);
        int idx = 0;
        int last;
        plan(n);
        last = i_exp[n-1] + (1 << OCC_W) + 3;
        for (int c = 0; c <= last; c++) begin
            int lvl = 0;
            bit popc = 0;
            logic [2:0] ev = '0;
            logic [2:0] eb = '0;
            int edat [3];
            @(negedge clk);
            rst_n = 1'b1;
            in_valid = (idx < n);
            if (idx < n) begin
                in_kind = 2'(c_kind[idx]);
                in_occ  = OCC_W'(c_occ[idx]);
                in_data = DATA_W'(c_data[idx]);
            end
            #1;
            for (int k = 0; k < 3; k++) edat[k] = 0;
            for (int j = 0; j < n; j++) begin
                if (e_exp[j] < c) lvl++;
                if (i_exp[j] < c) lvl--;
                if (i_exp[j] == c) begin
                    popc = 1;
                    ev[c_kind[j]] = 1'b1;
                    edat[c_kind[j]] = c_data[j];
                end
                if (i_exp[j] < c && c <= i_exp[j] + eff(c_occ[j])) eb[c_kind[j]] = 1'b1;
            end
            if (lvl == DEPTH && popc)
                chk(in_ready == 1'b1, "R3 full accept", int'(in_ready), 1);
            else
                chk(in_ready == (lvl < DEPTH || popc), "R2 ready", int'(in_ready),
                    int'(lvl < DEPTH || popc));
            chk(int'(q_level) == lvl, "R2 level", int'(q_level), lvl);
            chk($countones(iss_valid) <= 1, "R4 one per cycle", int'(iss_valid), int'(ev));
            chk(iss_valid == ev, "R5 R6 R9 dispatch", int'(iss_valid), int'(ev));
            for (int k = 0; k < 3; k++)
                if (ev[k]) chk(int'(iss_data[k*DATA_W +: DATA_W]) == edat[k], "R6 payload",
                               int'(iss_data[k*DATA_W +: DATA_W]), edat[k]);
            chk(seq_busy == eb, "R7 R8 R9 R10 busy", int'(seq_busy), int'(eb));
            chk(err_illegal == 1'b0, "R11 no err", int'(err_illegal), 0);
            if (in_valid && in_ready) idx++;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        // Sweep: same-kind trains over every occupancy, incl. 0 (R8, R10).
        for (int kd = 0; kd < 3; kd++) begin
            for (int oc = 0; oc < (1 << OCC_W); oc++) begin
                reset_dut();
                for (int i = 0; i < 4; i++) begin
                    c_kind[i] = kd;
                    c_occ[i]  = oc;
                    c_data[i] = 16 * kd + oc + i;
                end
                run(4);
            end
        end
        // Head blocking: load waits behind a stalled arith (R5).
        reset_dut();
        c_kind[0] = 0; c_occ[0] = 6; c_data[0] = 8'h11;
        c_kind[1] = 0; c_occ[1] = 2; c_data[1] = 8'h22;
        c_kind[2] = 1; c_occ[2] = 1; c_data[2] = 8'h33;
        run(3);
        chk(i_exp[2] == 8, "R5 planned head block", i_exp[2], 8);
        // All three busy together (R9).
        reset_dut();
        c_kind[0] = 0; c_occ[0] = 6; c_data[0] = 8'h41;
        c_kind[1] = 1; c_occ[1] = 4; c_data[1] = 8'h42;
        c_kind[2] = 2; c_occ[2] = 2; c_data[2] = 8'h43;
        run(3);
        // Pseudo-random mixed sequences.
        for (int r = 0; r < 40; r++) begin
            reset_dut();
            for (int i = 0; i < 12; i++) begin
                c_kind[i] = rnd(3);
                c_occ[i]  = rnd(1 << OCC_W);
                c_data[i] = rnd(256);
            end
            run(12);
        end
        // Illegal kind at the head (R11), then reset clears it (R1).
        reset_dut();
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            rst_n = 1'b1;
            in_valid = (c < 2);
            in_kind  = (c == 0) ? 2'b11 : 2'b00;
            in_occ   = OCC_W'(2);
            in_data  = DATA_W'(c + 1);
            #1;
            if (c >= 2) begin
                chk(err_illegal == 1'b1, "R11 err flag", int'(err_illegal), 1);
                chk(iss_valid == 3'b000, "R11 no dispatch", int'(iss_valid), 0);
                chk(q_level == 2, "R11 level held", int'(q_level), 2);
            end
        end
        reset_dut();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule